// File: doc/BRIEF.md
# Multi-Lane Deskew Buffer with Fixed Release Latency

This block takes several receive lanes, each delivering one octet per clock. Because of routing and serializer differences, the lanes arrive with different delays, so each lane holds its data in its own small buffer. Every lane starts storing at the octet flagged by its start marker, which is the first octet of its alignment sequence. All lanes are then released together on one common clock.

The release instant is not set by how full the buffers are. It is set by a programmed frame offset (the release delay) counted from a multiframe boundary pulse. The first released octet therefore always leaves at the same phase of the multiframe, no matter how the lanes were skewed or how often the link is re-aligned.

A small state machine controls the block. It has three states:
- `ST_IDLE`: no lane has marked yet.
- `ST_FILL`: at least one lane has marked, and the block waits for a release opportunity.
- `ST_RUN`: all lanes are read in lockstep.

It has these transitions:
- IDLE→FILL, taken when the first marker arrives.
- FILL→RUN, taken at a release opportunity once every lane has marked.
- FILL→FILL, taken at a release opportunity when a lane is still missing. This sets the late flag.
- Any state→IDLE, taken on a resynchronization pulse.

Top module: `lane_deskew_buffer`

## Requirements
- R1: A lane stores octets only from the cycle in which `lane_vld` and `lane_sos` are both high for that lane. Octets presented before that cycle are ignored and never appear at the output.
- R2: The release opportunity is the cycle that carries the Nth `frame_ce` pulse after a cycle with `lmfc_pulse`. N is the effective release delay. A `frame_ce` in the pulse cycle itself is not counted, and each new `lmfc_pulse` restarts the count.
- R3: The effective release delay is `rbd_cfg` clamped to the range 1 to K. A value of 0 acts as 1, and a value above K acts as K. K is `k_cfg`, with 0 treated as 1.
- R4: In FILL, if every lane's marker was seen in an earlier cycle, a release opportunity moves the FSM to RUN. `out_vld` is then high from the next cycle until a resynchronization.
- R5: In RUN every lane gives up one octet per clock, all on the same clock. Lane i appears on `out_data[8i+7:8i]` in arrival order, so the marked octets of all lanes appear in the same cycle.
- R6: If a release opportunity arrives in FILL while any lane has not yet marked, `err_late` is set. It stays set until a resynchronization, and release waits for a later opportunity.
- R7: If a lane already holds DEPTH octets and gets a write in a cycle without a read, the new octet is dropped and `err_overflow` is set. The flag stays set until a resynchronization.
- R8: A cycle with `resync` high empties all lanes and forgets all markers. It clears both error flags and returns to IDLE, so `out_vld` is low in the next cycle. The boundary/frame counting is not disturbed.
- R9: When all lanes mark in time, the first valid output cycle sits at the same offset from the last boundary pulse for any lane skew. That offset depends only on the release delay.
- R10: After reset, `out_vld`, `err_late` and `err_overflow` are low and the FSM is in IDLE.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| resync | input | 1 | Start a new alignment: flush lanes, clear flags |
| lane_vld | input | NUM_LANES | Octet valid, one bit per lane |
| lane_sos | input | NUM_LANES | Start-of-sequence marker, one bit per lane |
| lane_data | input | NUM_LANES*8 | Octet per lane, lane i at bits [8i+7:8i] |
| lmfc_pulse | input | 1 | Multiframe boundary pulse |
| frame_ce | input | 1 | Frame-cycle enable |
| rbd_cfg | input | KW | Programmed release delay in frames |
| k_cfg | input | KW | Frames per multiframe |
| out_data | output | NUM_LANES*8 | Deskewed lane octets, lane i at bits [8i+7:8i] |
| out_vld | output | 1 | Released data valid |
| err_overflow | output | 1 | Sticky lane overflow flag |
| err_late | output | 1 | Sticky late-lane flag |

## Verification
The assertions rely on a few assumptions about the inputs:
- `rbd_cfg` and `k_cfg` stay steady while an alignment is in progress.
- Once a lane has marked, it supplies an octet on every clock, so a lockstep read never meets an empty lane.
- Each lane gives one marker per alignment.

The stimulus meets these assumptions:
- It changes the configuration only in the cycle of a resynchronization pulse.
- It keeps every started lane streaming without gaps, with junk octets before each marker.
- It starts every scenario just after a boundary pulse, so the skew chosen for each lane places its marker before or after a known opportunity.

// File: rtl/eb_pkg.sv
package eb_pkg;
    localparam int OCTET_W = 8;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_FILL = 2'd1,
        ST_RUN  = 2'd2
    } eb_state_e;
endpackage

// File: rtl/eb_release_timer.sv
module eb_release_timer #(
    parameter int KW = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          lmfc_pulse,
    input  logic          frame_ce,
    input  logic [KW-1:0] rbd_cfg,
    input  logic [KW-1:0] k_cfg,
    output logic          rel_opp
);
    logic [KW-1:0] k_eff;
    logic [KW-1:0] rbd_eff;
    logic [KW-1:0] remain;
    logic          armed;

    // clamp the programmed delay into 1..K
    always_comb begin
        k_eff = (k_cfg == '0) ? KW'(1) : k_cfg;
        if (rbd_cfg == '0) begin
            rbd_eff = KW'(1);
        end else if (rbd_cfg > k_eff) begin
            rbd_eff = k_eff;
        end else begin
            rbd_eff = rbd_cfg;
        end
    end

    assign rel_opp = armed && frame_ce && (remain == KW'(1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            armed  <= 1'b0;
            remain <= '0;
        end else if (lmfc_pulse) begin
            armed  <= 1'b1;
            remain <= rbd_eff;
        end else if (armed && frame_ce) begin
            if (remain == KW'(1)) begin
                armed <= 1'b0;
            end else begin
                remain <= remain - KW'(1);
            end
        end
    end

    AST_REMAIN_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
        armed |-> (remain != '0));  // R2

    AST_DELAY_CLAMPED: assert property (@(posedge clk) disable iff (!rst_n)
        lmfc_pulse |=> (remain >= KW'(1)) && (remain <= $past(k_eff)));  // R3
endmodule

// File: rtl/eb_lane_fifo.sv
module eb_lane_fifo #(
    parameter int DEPTH = 32,
    parameter int AW    = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          in_vld,
    input  logic          in_sos,
    input  logic [7:0]    in_data,
    input  logic          rd_en,
    output logic          started,
    output logic [7:0]    rd_data,
    output logic [AW-1:0] rd_idx,
    output logic          ovf_evt
);
    localparam int OW = AW + 1;

    logic [7:0]    mem [DEPTH];
    logic [AW-1:0] wr_ptr;
    logic [AW-1:0] rd_ptr;
    logic [OW-1:0] occ;
    logic          wr_ok;
    logic          full;
    logic          do_wr;
    logic          rd_dec;

    function automatic logic [AW-1:0] step_ptr(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
    endfunction

    always_comb begin
        wr_ok   = in_vld && (started || in_sos);
        full    = (occ == OW'(DEPTH));
        ovf_evt = wr_ok && full && !rd_en;
        do_wr   = wr_ok && !ovf_evt;
        rd_dec  = rd_en && (occ != '0);
    end

    assign rd_data = mem[rd_ptr];
    assign rd_idx  = rd_ptr;

    always_ff @(posedge clk) begin
        if (do_wr && !clr) begin
            mem[wr_ptr] <= in_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            started <= 1'b0;
            wr_ptr  <= '0;
            rd_ptr  <= '0;
            occ     <= '0;
        end else if (clr) begin
            started <= 1'b0;
            wr_ptr  <= '0;
            rd_ptr  <= '0;
            occ     <= '0;
        end else begin
            if (in_vld && in_sos) begin
                started <= 1'b1;
            end
            if (do_wr) begin
                wr_ptr <= step_ptr(wr_ptr);
            end
            if (rd_en) begin
                rd_ptr <= step_ptr(rd_ptr);
            end
            unique case ({do_wr, rd_dec})
                2'b10:   occ <= occ + OW'(1);
                2'b01:   occ <= occ - OW'(1);
                default: occ <= occ;
            endcase
        end
    end

    AST_OCC_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        occ <= OW'(DEPTH));  // R7

    AST_IGNORE_BEFORE_MARK: assert property (@(posedge clk) disable iff (!rst_n)
        (!started && !(in_vld && in_sos) && !clr) |=> $stable(wr_ptr));  // R1
endmodule

// File: rtl/lane_deskew_buffer.sv
module lane_deskew_buffer
    import eb_pkg::*;
#(
    parameter int NUM_LANES = 4,
    parameter int DEPTH     = 32,
    parameter int KW        = 6
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   resync,
    input  logic [NUM_LANES-1:0]   lane_vld,
    input  logic [NUM_LANES-1:0]   lane_sos,
    input  logic [NUM_LANES*8-1:0] lane_data,
    input  logic                   lmfc_pulse,
    input  logic                   frame_ce,
    input  logic [KW-1:0]          rbd_cfg,
    input  logic [KW-1:0]          k_cfg,
    output logic [NUM_LANES*8-1:0] out_data,
    output logic                   out_vld,
    output logic                   err_overflow,
    output logic                   err_late
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    eb_state_e              state_q;
    eb_state_e              state_d;
    logic [NUM_LANES-1:0]   started;
    logic [NUM_LANES-1:0]   ovf_evt;
    logic [AW-1:0]          rd_idx [NUM_LANES];
    logic                   rel_opp;
    logic                   all_started;
    logic                   any_mark;
    logic                   rd_en;

    eb_release_timer #(.KW(KW)) u_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .lmfc_pulse (lmfc_pulse),
        .frame_ce   (frame_ce),
        .rbd_cfg    (rbd_cfg),
        .k_cfg      (k_cfg),
        .rel_opp    (rel_opp)
    );

    for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
        eb_lane_fifo #(.DEPTH(DEPTH), .AW(AW)) u_lane (
            .clk     (clk),
            .rst_n   (rst_n),
            .clr     (resync),
            .in_vld  (lane_vld[g]),
            .in_sos  (lane_sos[g]),
            .in_data (lane_data[g*OCTET_W +: OCTET_W]),
            .rd_en   (rd_en),
            .started (started[g]),
            .rd_data (out_data[g*OCTET_W +: OCTET_W]),
            .rd_idx  (rd_idx[g]),
            .ovf_evt (ovf_evt[g])
        );

        if (g > 0) begin : g_lock
            AST_LOCKSTEP: assert property (@(posedge clk) disable iff (!rst_n)
                rd_idx[g] == rd_idx[0]);  // R5
        end
    end

    assign all_started = &started;
    assign any_mark    = |(lane_vld & lane_sos);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        if (resync) begin
            state_d = ST_IDLE;
        end else begin
            unique case (state_q)
                ST_IDLE: if (any_mark)                  state_d = ST_FILL;
                ST_FILL: if (rel_opp && all_started)    state_d = ST_RUN;
                ST_RUN:                                 state_d = ST_RUN;
                default:                                state_d = ST_IDLE;
            endcase
        end
    end

    // sticky error flags
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            err_overflow <= 1'b0;
            err_late     <= 1'b0;
        end else if (resync) begin
            err_overflow <= 1'b0;
            err_late     <= 1'b0;
        end else begin
            if (|ovf_evt) begin
                err_overflow <= 1'b1;
            end
            if ((state_q == ST_FILL) && rel_opp && !all_started) begin
                err_late <= 1'b1;
            end
        end
    end

    // outputs
    always_comb begin
        out_vld = (state_q == ST_RUN);
        rd_en   = out_vld;
    end

    AST_RUN_ALL_MARKED: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN) |-> all_started);  // R4

    AST_VLD_RISE_AT_OPP: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(out_vld) |-> $past(rel_opp));  // R4

    AST_LATE_AT_OPP: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_late) |-> ($past(rel_opp) && ($past(state_q) == ST_FILL)));  // R6

    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (err_overflow && !resync) |=> err_overflow);  // R7

    AST_RESYNC_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        resync |=> (!out_vld && !err_late && !err_overflow));  // R8
endmodule

// File: tb/sim_lane_deskew_buffer.sv
module sim_lane_deskew_buffer;
    localparam int CLK_PERIOD = 10;
    localparam int NL  = 4;
    localparam int DEP = 32;
    localparam int KW  = 6;

    logic            clk = 1'b0;
    logic            rst_n;
    logic            resync;
    logic [NL-1:0]   lane_vld;
    logic [NL-1:0]   lane_sos;
    logic [NL*8-1:0] lane_data;
    logic            lmfc_pulse;
    logic            frame_ce;
    logic [KW-1:0]   rbd_cfg;
    logic [KW-1:0]   k_cfg;
    logic [NL*8-1:0] out_data;
    logic            out_vld;
    logic            err_overflow;
    logic            err_late;

    always #(CLK_PERIOD/2) clk = ~clk;

    lane_deskew_buffer #(.NUM_LANES(NL), .DEPTH(DEP), .KW(KW)) u0 (
        .clk(clk), .rst_n(rst_n), .resync(resync), .lane_vld(lane_vld),
        .lane_sos(lane_sos), .lane_data(lane_data), .lmfc_pulse(lmfc_pulse),
        .frame_ce(frame_ce), .rbd_cfg(rbd_cfg), .k_cfg(k_cfg),
        .out_data(out_data), .out_vld(out_vld), .err_overflow(err_overflow),
        .err_late(err_late)
    );

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;
    int cyc = 0, t = 0, fdiv = 1, kval = 8, fidx = 0, last_lmfc = 0;
    int skew [NL];
    bit lanes_on = 0, lmfc_drv = 0, prev_vld = 0, meas_phase = 0;
    int got_phase = -1;

    // reference model state
    byte unsigned mq [NL][$];
    bit  mstart [NL];
    int  mstate = 0;
    bit  movf = 0, mlate = 0, marmed = 0;
    int  mremain = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s act=%0d exp=%0d", req, what, act, exp);
        end
    endtask

    task automatic model_clear();
        for (int i = 0; i < NL; i++) begin
            mq[i].delete();
            mstart[i] = 0;
        end
        mstate = 0;
        movf = 0;
        mlate = 0;
    endtask

    task automatic model_update();
        int  k, r;
        bit  opp, rd, allst, anym, wr_ok, full;
        k = (k_cfg == 0) ? 1 : int'(k_cfg);
        r = (rbd_cfg == 0) ? 1 : ((int'(rbd_cfg) > k) ? k : int'(rbd_cfg));
        opp = marmed && frame_ce && (mremain == 1);
        if (lmfc_pulse) begin
            marmed = 1;
            mremain = r;
        end else if (marmed && frame_ce) begin
            if (mremain == 1) marmed = 0;
            else mremain--;
        end
        if (resync) begin
            model_clear();
        end else begin
            rd = (mstate == 2);
            allst = 1;
            anym = 0;
            for (int i = 0; i < NL; i++) allst &= mstart[i];
            for (int i = 0; i < NL; i++) begin
                wr_ok = lane_vld[i] && (mstart[i] || lane_sos[i]);
                full = (mq[i].size() == DEP);
                if (rd && mq[i].size() > 0) void'(mq[i].pop_front());
                if (wr_ok) begin
                    if (full && !rd) movf = 1;
                    else mq[i].push_back(lane_data[i*8 +: 8]);
                end
                if (lane_vld[i] && lane_sos[i]) begin
                    mstart[i] = 1;
                    anym = 1;
                end
            end
            if (mstate == 0 && anym) mstate = 1;
            else if (mstate == 1 && opp) begin
                if (allst) mstate = 2;
                else mlate = 1;
            end
        end
    endtask

    task automatic drive();
        frame_ce = ((cyc % fdiv) == 0);
        lmfc_pulse = frame_ce && (fidx == 0);
        lmfc_drv = lmfc_pulse;
        if (frame_ce) fidx = (fidx + 1) % kval;
        if (lmfc_pulse) last_lmfc = cyc;
        for (int i = 0; i < NL; i++) begin
            if (!lanes_on) begin
                lane_vld[i] = 0; lane_sos[i] = 0; lane_data[i*8 +: 8] = 8'h00;
            end else if (t < skew[i]) begin
                lane_vld[i] = 1; lane_sos[i] = 0; lane_data[i*8 +: 8] = 8'hEE;
            end else begin
                lane_vld[i] = 1;
                lane_sos[i] = (t == skew[i]);
                lane_data[i*8 +: 8] = 8'(i*64 + t - skew[i]);
            end
        end
    endtask

    task automatic compare();
        bit ev;
        ev = (mstate == 2);
        chk(out_vld === ev, "R4", "out_vld", int'(out_vld), int'(ev));
        chk(err_late === mlate, "R6", "err_late", int'(err_late), int'(mlate));
        chk(err_overflow === movf, "R7", "err_overflow", int'(err_overflow), int'(movf));
        if (ev) begin
            for (int i = 0; i < NL; i++) begin
                if (mq[i].size() > 0)
                    chk(out_data[i*8 +: 8] === mq[i][0], "R5", "lane octet",
                        int'(out_data[i*8 +: 8]), int'(mq[i][0]));
            end
        end
        if (out_vld && !prev_vld) begin
            for (int i = 0; i < NL; i++)   // R1: first released octet is the marked one
                chk(out_data[i*8 +: 8] === 8'(i*64), "R1", "first octet",
                    int'(out_data[i*8 +: 8]), i*64 % 256);
            if (meas_phase) got_phase = (cyc + 1 - last_lmfc) % kval;
        end
        prev_vld = out_vld;
    endtask

    task automatic step();
        drive();
        @(posedge clk);
        model_update();
        @(negedge clk);
        compare();
        cyc++;
        if (lanes_on) t++;
    endtask

    task automatic run(input int n);
        for (int i = 0; i < n; i++) step();
    endtask

    task automatic begin_scn(input int k, input int rbd, input int fd,
                             input int s0, input int s1, input int s2, input int s3,
                             input bit meas);
        k_cfg = KW'(k);
        rbd_cfg = KW'(rbd);
        kval = (k == 0) ? 1 : k;
        fdiv = fd;
        fidx = 0;
        lanes_on = 0;
        resync = 1;
        step();
        resync = 0;
        // R8: resync empties and clears
        chk(!out_vld && !err_late && !err_overflow, "R8", "cleared after resync",
            int'({out_vld, err_late, err_overflow}), 0);
        do step(); while (!lmfc_drv);
        skew[0] = s0; skew[1] = s1; skew[2] = s2; skew[3] = s3;
        t = 0;
        lanes_on = 1;
        meas_phase = meas;
        got_phase = -1;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL R4 watchdog act=0 exp=1");
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        int p1;
        rst_n = 0; resync = 0; lane_vld = '0; lane_sos = '0; lane_data = '0;
        lmfc_pulse = 0; frame_ce = 0; rbd_cfg = KW'(6); k_cfg = KW'(8);
        for (int i = 0; i < NL; i++) skew[i] = 0;
        model_clear();
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R10: reset state
        chk(out_vld === 1'b0, "R10", "out_vld after reset", int'(out_vld), 0);
        chk(err_late === 1'b0 && err_overflow === 1'b0, "R10", "flags after reset",
            int'({err_late, err_overflow}), 0);

        // nominal skew, delay 6 of 8
        begin_scn(8, 6, 1, 0, 1, 2, 3, 1);
        run(60);
        chk(got_phase == 7, "R2", "release phase", got_phase, 7);
        chk(!err_late && !err_overflow, "R6", "no error in time", int'({err_late, err_overflow}), 0);
        p1 = got_phase;

        // different skew, same latency
        begin_scn(8, 6, 1, 3, 0, 2, 1, 1);
        run(60);
        chk(got_phase == p1, "R9", "latency repeat", got_phase, p1);

        // delay 0 acts as 1
        begin_scn(8, 0, 1, 0, 0, 0, 0, 1);
        run(40);
        chk(got_phase == 2, "R3", "clamp low phase", got_phase, 2);

        // delay above K acts as K
        begin_scn(8, 20, 1, 0, 2, 1, 0, 1);
        run(40);
        chk(got_phase == 1, "R3", "clamp high phase", got_phase, 1);

        // late lane
        begin_scn(8, 2, 1, 0, 0, 0, 10, 1);
        run(60);
        chk(err_late === 1'b1, "R6", "late flag", int'(err_late), 1);
        chk(got_phase == 3, "R6", "late release phase", got_phase, 3);
        chk(err_overflow === 1'b0, "R7", "no overflow", int'(err_overflow), 0);

        // overflow from a very late lane
        begin_scn(8, 2, 1, 0, 0, 0, 40, 0);
        run(80);
        chk(err_overflow === 1'b1, "R7", "overflow flag", int'(err_overflow), 1);
        chk(out_vld === 1'b1, "R7", "release after overflow", int'(out_vld), 1);

        // slow frame enable
        begin_scn(4, 3, 2, 1, 0, 1, 0, 0);
        run(80);
        chk(out_vld === 1'b1, "R2", "release with slow frames", int'(out_vld), 1);

        done = 1;
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule